// File: doc/BRIEF.md
# Chained Watchpoint and Breakpoint Unit

This block watches the processor's memory traffic and decides, in every cycle that carries an access, which of eleven watchpoints match. Eight programmable comparators each test one operand of the access (the fetch address, the load or store address, or the load or store data) against a stored value, using one of seven conditions in signed or unsigned form. The comparator results feed a chain. Each watchpoint can stand alone, or be ANDed or ORed with the watchpoint just below it, so several conditions can be combined into one event. Watchpoints 8 and 9 take their own term from two event counters, which fire when their count equals a programmed limit. Watchpoint 10 takes its own term from an external watchpoint pin.

A watchpoint that goes from clear to set is a new match. A new match can step one of the two shared counters, and it can raise a one-cycle breakpoint request. The access streams carry no back-pressure: each is a plain valid strobe with its operands, and the unit samples every strobe in the cycle it is high. All configuration is written through a simple write-only register bus.

Top module: `watch_chain_unit`

## Requirements
- R1: After reset the watchpoint status and the breakpoint request are 0. All configuration registers are 0, and both counters have count 0 and limit 0.
- R2: A comparator can hit only when its armed bit (control bit 0) is set and its operand select (control bits 7:5) is neither 0 nor 7.
- R3: The operand select picks the operand: 1 = fetch address, 2 = load address, 3 = store address, 4 = load data, 5 = store data, 6 = load-or-store address. The operand counts only while its own stream strobe is high. For select 6 the load address is used when the load strobe is high, and otherwise the store address is used.
- R4: The condition field (control bits 3:1) selects the test of operand against value: 0 = nonzero bitwise AND, 1 = equal, 2 = not equal, 3 = less, 4 = less-or-equal, 5 = greater, 6 = greater-or-equal, 7 = never.
- R5: Control bit 4 makes the ordering conditions compare both sides as two's-complement numbers. When it is clear they compare as unsigned numbers.
- R6: Watchpoint i reads a 2-bit link mode from bits 2i+1:2i of the link register. Mode 0 uses its own term, 1 ANDs the own term with the current match of watchpoint i-1, 2 ORs them, and 3 never matches. For watchpoint 0, modes 1 and 2 act as mode 0.
- R7: The own term of watchpoint 8 is count==limit of counter 0, and that of watchpoint 9 is count==limit of counter 1. Both use the count held before the current cycle's step. Watchpoints 8 and 9 chain with watchpoints 7 and 8 respectively.
- R8: The own term of watchpoint 10 is the external watchpoint input, and watchpoint 10 chains with watchpoint 9.
- R9: A cycle with at least one stream strobe high is an evaluation cycle. Only in such a cycle does the status register load the current match vector. In all other cycles it holds, whatever the operands and the external input do.
- R10: A new match is a watchpoint that matches in an evaluation cycle while its status bit is clear. Each new match steps the counter chosen by its bit in the counter-select register (0 = counter 0, 1 = counter 1), provided that counter's enable bit (bit 0 or bit 1 of the enable register) is set. Several new matches on the same counter in one cycle add together, and the count wraps.
- R11: The breakpoint request is high for exactly the one cycle after an evaluation cycle in which some new match has its bit set in the breakpoint mask.
- R12: The write bus maps the default configuration as follows: address i (0 to 7) holds the value of comparator i, address 8+i holds its control, 16 holds the link register, 17 the counter-select register, 18 the enable register, 19 the breakpoint mask, and 20 and 21 hold counters 0 and 1 (count in the low 16 bits, limit above it). A counter write in the same cycle as a step keeps the written value. Writes to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_vld | input | 1 | Instruction fetch strobe |
| fetch_addr | input | DATA_W | Fetch effective address |
| ld_vld | input | 1 | Load strobe |
| ld_addr | input | DATA_W | Load effective address |
| ld_data | input | DATA_W | Load data |
| st_vld | input | 1 | Store strobe |
| st_addr | input | DATA_W | Store effective address |
| st_data | input | DATA_W | Store data |
| ext_wp | input | 1 | External watchpoint term |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | ADDR_W | Configuration register address |
| cfg_wdata | input | CFG_W | Configuration write data |
| wp_status | output | NUM_CMP+3 | Registered watchpoint match vector |
| bp_req | output | 1 | One-cycle breakpoint request |

## Verification
The bench builds the unit with DATA_W = 4 and CNT_W = 4 and keeps the eight comparators. The narrow data path makes it possible to sweep every operand/value pair under all condition codes, in both signed and unsigned form, and to compute each expected result arithmetically. The 4-bit counters reach their wrap point within a handful of new matches. Because a counter can be programmed so that count equals limit, the chain through watchpoints 8 to 10 and the counting rules can be observed at the status port alone.

// File: rtl/wcu_pkg.sv
package wcu_pkg;

  // operand picked by a comparator
  typedef enum logic [2:0] {
    SRC_NONE     = 3'd0,
    SRC_FETCH    = 3'd1,
    SRC_LD_ADDR  = 3'd2,
    SRC_ST_ADDR  = 3'd3,
    SRC_LD_DATA  = 3'd4,
    SRC_ST_DATA  = 3'd5,
    SRC_LS_ADDR  = 3'd6,
    SRC_NONE_ALT = 3'd7
  } opnd_src_e;

  // condition tested between operand and stored value
  typedef enum logic [2:0] {
    CC_MASK  = 3'd0,
    CC_EQ    = 3'd1,
    CC_NE    = 3'd2,
    CC_LT    = 3'd3,
    CC_LE    = 3'd4,
    CC_GT    = 3'd5,
    CC_GE    = 3'd6,
    CC_NEVER = 3'd7
  } cond_e;

  // how a watchpoint combines with its lower neighbour
  typedef enum logic [1:0] {
    LK_SELF = 2'd0,
    LK_AND  = 2'd1,
    LK_OR   = 2'd2,
    LK_OFF  = 2'd3
  } link_e;

  // comparator control word: [7:5] source, [4] signed, [3:1] condition, [0] armed
  typedef struct packed {
    opnd_src_e src;
    logic      is_signed;
    cond_e     cond;
    logic      armed;
  } cmp_ctrl_t;

  localparam int CTRL_W = $bits(cmp_ctrl_t);

endpackage

// File: rtl/wcu_cmp.sv
module wcu_cmp
  import wcu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  cmp_ctrl_t         ctrl,
  input  logic [DATA_W-1:0] ref_val,
  input  logic              fetch_vld,
  input  logic [DATA_W-1:0] fetch_addr,
  input  logic              ld_vld,
  input  logic [DATA_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              st_vld,
  input  logic [DATA_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  output logic              hit
);

  logic [DATA_W-1:0] opnd;
  logic              opnd_ok;
  logic              is_eq;
  logic              is_lt;
  logic              cond_true;

  // operand mux; a source is live only while its stream strobe is high
  always_comb begin
    opnd    = '0;
    opnd_ok = 1'b0;
    case (ctrl.src)
      SRC_FETCH:   begin opnd = fetch_addr; opnd_ok = fetch_vld; end
      SRC_LD_ADDR: begin opnd = ld_addr;    opnd_ok = ld_vld;    end
      SRC_ST_ADDR: begin opnd = st_addr;    opnd_ok = st_vld;    end
      SRC_LD_DATA: begin opnd = ld_data;    opnd_ok = ld_vld;    end
      SRC_ST_DATA: begin opnd = st_data;    opnd_ok = st_vld;    end
      SRC_LS_ADDR: begin
        if (ld_vld) begin
          opnd    = ld_addr;
          opnd_ok = 1'b1;
        end else begin
          opnd    = st_addr;
          opnd_ok = st_vld;
        end
      end
      default: begin opnd = '0; opnd_ok = 1'b0; end
    endcase
  end

  assign is_eq = (opnd == ref_val);
  assign is_lt = ctrl.is_signed ? ($signed(opnd) < $signed(ref_val))
                                : (opnd < ref_val);

  always_comb begin
    case (ctrl.cond)
      CC_MASK: cond_true = |(opnd & ref_val);
      CC_EQ:   cond_true = is_eq;
      CC_NE:   cond_true = !is_eq;
      CC_LT:   cond_true = is_lt;
      CC_LE:   cond_true = is_lt | is_eq;
      CC_GT:   cond_true = !(is_lt | is_eq);
      CC_GE:   cond_true = !is_lt;
      default: cond_true = 1'b0;
    endcase
  end

  assign hit = ctrl.armed & opnd_ok & cond_true;

endmodule

// File: rtl/wcu_chain.sv
module wcu_chain
  import wcu_pkg::*;
#(
  parameter int NUM_CMP = 8
) (
  input  logic [NUM_CMP-1:0]       cmp_hit,
  input  logic [1:0]               cnt_equal,
  input  logic                     ext_wp,
  input  logic [2*NUM_CMP+5:0]     link_cfg,
  output logic [NUM_CMP+2:0]       match
);

  localparam int NUM_WP = NUM_CMP + 3;

  logic [NUM_WP-1:0] own;

  // own terms: comparators, then the two counters, then the external pin
  assign own = {ext_wp, cnt_equal[1], cnt_equal[0], cmp_hit};

  // ripple from watchpoint 0 upward; watchpoint 0 sees itself as predecessor
  always_comb begin
    logic carry;
    match = '0;
    carry = own[0];
    for (int i = 0; i < NUM_WP; i++) begin
      case (link_e'(link_cfg[2*i +: 2]))
        LK_SELF: match[i] = own[i];
        LK_AND:  match[i] = own[i] & carry;
        LK_OR:   match[i] = own[i] | carry;
        default: match[i] = 1'b0;
      endcase
      carry = match[i];
    end
  end

endmodule

// File: rtl/wcu_counter.sv
module wcu_counter #(
  parameter int CNT_W  = 16,
  parameter int STEP_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2*CNT_W-1:0] wr_data,
  input  logic [STEP_W-1:0]  step,
  output logic               equal
);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] limit_q;

  // a bus write wins over a step in the same cycle; the sum wraps
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      limit_q <= '0;
    end else if (wr_en) begin
      count_q <= wr_data[CNT_W-1:0];
      limit_q <= wr_data[2*CNT_W-1:CNT_W];
    end else begin
      count_q <= count_q + CNT_W'(step);
    end
  end

  assign equal = (count_q == limit_q);

endmodule

// File: rtl/wcu_cfg.sv
module wcu_cfg
  import wcu_pkg::*;
#(
  parameter int NUM_CMP = 8,
  parameter int DATA_W  = 32,
  parameter int CFG_W   = 32,
  parameter int ADDR_W  = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [ADDR_W-1:0]               cfg_addr,
  input  logic [CFG_W-1:0]                cfg_wdata,
  output logic [NUM_CMP-1:0][DATA_W-1:0]  ref_vals,
  output cmp_ctrl_t [NUM_CMP-1:0]         ctrls,
  output logic [2*NUM_CMP+5:0]            link_cfg,
  output logic [NUM_CMP+2:0]              cnt_sel,
  output logic [NUM_CMP+2:0]              bp_mask,
  output logic [1:0]                      cnt_en,
  output logic [1:0]                      cnt_wr
);

  localparam int NUM_WP = NUM_CMP + 3;
  localparam int A_CTRL = NUM_CMP;
  localparam int A_LINK = 2 * NUM_CMP;
  localparam int A_SEL  = A_LINK + 1;
  localparam int A_EN   = A_LINK + 2;
  localparam int A_BP   = A_LINK + 3;
  localparam int A_CNT0 = A_LINK + 4;
  localparam int A_CNT1 = A_LINK + 5;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_vals <= '0;
      ctrls    <= '0;
      link_cfg <= '0;
      cnt_sel  <= '0;
      bp_mask  <= '0;
      cnt_en   <= '0;
    end else if (cfg_we) begin
      for (int s = 0; s < NUM_CMP; s++) begin
        if (cfg_addr == ADDR_W'(s))
          ref_vals[s] <= cfg_wdata[DATA_W-1:0];
        if (cfg_addr == ADDR_W'(A_CTRL + s))
          ctrls[s] <= cmp_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
      end
      if (cfg_addr == ADDR_W'(A_LINK)) link_cfg <= cfg_wdata[2*NUM_WP-1:0];
      if (cfg_addr == ADDR_W'(A_SEL))  cnt_sel  <= cfg_wdata[NUM_WP-1:0];
      if (cfg_addr == ADDR_W'(A_EN))   cnt_en   <= cfg_wdata[1:0];
      if (cfg_addr == ADDR_W'(A_BP))   bp_mask  <= cfg_wdata[NUM_WP-1:0];
    end
  end

  // counter registers live in the counters; only the strobes come from here
  assign cnt_wr[0] = cfg_we && (cfg_addr == ADDR_W'(A_CNT0));
  assign cnt_wr[1] = cfg_we && (cfg_addr == ADDR_W'(A_CNT1));

endmodule

// File: rtl/watch_chain_unit.sv
module watch_chain_unit
  import wcu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  parameter int NUM_CMP = 8,
  parameter int CFG_W   = 32,
  parameter int ADDR_W  = $clog2(2 * NUM_CMP + 6)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fetch_vld,
  input  logic [DATA_W-1:0]    fetch_addr,
  input  logic                 ld_vld,
  input  logic [DATA_W-1:0]    ld_addr,
  input  logic [DATA_W-1:0]    ld_data,
  input  logic                 st_vld,
  input  logic [DATA_W-1:0]    st_addr,
  input  logic [DATA_W-1:0]    st_data,
  input  logic                 ext_wp,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [CFG_W-1:0]     cfg_wdata,
  output logic [NUM_CMP+2:0]   wp_status,
  output logic                 bp_req
);

  localparam int NUM_WP = NUM_CMP + 3;
  localparam int STEP_W = $clog2(NUM_WP + 1);

  logic [NUM_CMP-1:0][DATA_W-1:0] ref_vals;
  cmp_ctrl_t [NUM_CMP-1:0]        ctrls;
  logic [2*NUM_WP-1:0]            link_cfg;
  logic [NUM_WP-1:0]              cnt_sel;
  logic [NUM_WP-1:0]              bp_mask;
  logic [1:0]                     cnt_en;
  logic [1:0]                     cnt_wr;
  logic [NUM_CMP-1:0]             cmp_hit;
  logic [1:0]                     cnt_eq;
  logic [NUM_WP-1:0]              match;
  logic [NUM_WP-1:0]              fresh;
  logic [NUM_WP-1:0]              status_q;
  logic                           bp_q;
  logic                           any_vld;
  logic [1:0][STEP_W-1:0]         step;

  wcu_cfg #(
    .NUM_CMP (NUM_CMP),
    .DATA_W  (DATA_W),
    .CFG_W   (CFG_W),
    .ADDR_W  (ADDR_W)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .ref_vals  (ref_vals),
    .ctrls     (ctrls),
    .link_cfg  (link_cfg),
    .cnt_sel   (cnt_sel),
    .bp_mask   (bp_mask),
    .cnt_en    (cnt_en),
    .cnt_wr    (cnt_wr)
  );

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    wcu_cmp #(.DATA_W(DATA_W)) u_cmp (
      .ctrl       (ctrls[g]),
      .ref_val    (ref_vals[g]),
      .fetch_vld  (fetch_vld),
      .fetch_addr (fetch_addr),
      .ld_vld     (ld_vld),
      .ld_addr    (ld_addr),
      .ld_data    (ld_data),
      .st_vld     (st_vld),
      .st_addr    (st_addr),
      .st_data    (st_data),
      .hit        (cmp_hit[g])
    );
  end

  wcu_chain #(.NUM_CMP(NUM_CMP)) u_chain (
    .cmp_hit   (cmp_hit),
    .cnt_equal (cnt_eq),
    .ext_wp    (ext_wp),
    .link_cfg  (link_cfg),
    .match     (match)
  );

  assign any_vld = fetch_vld | ld_vld | st_vld;
  assign fresh   = match & ~status_q;

  // per-counter step: number of new matches routed to it this cycle
  always_comb begin
    step = '0;
    for (int i = 0; i < NUM_WP; i++)
      if (fresh[i]) step[cnt_sel[i]] = step[cnt_sel[i]] + STEP_W'(1);
    for (int k = 0; k < 2; k++)
      if (!(any_vld && cnt_en[k])) step[k] = '0;
  end

  for (genvar k = 0; k < 2; k++) begin : g_cnt
    wcu_counter #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cnt_wr[k]),
      .wr_data (cfg_wdata[2*CNT_W-1:0]),
      .step    (step[k]),
      .equal   (cnt_eq[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      bp_q     <= 1'b0;
    end else if (any_vld) begin
      status_q <= match;
      bp_q     <= |(fresh & bp_mask);
    end else begin
      bp_q     <= 1'b0;
    end
  end

  assign wp_status = status_q;
  assign bp_req    = bp_q;

endmodule

// File: rtl/watch_chain_unit_sva.sv
module watch_chain_unit_sva
  import wcu_pkg::*;
#(
  parameter int NUM_CMP = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    any_vld,
  input logic [NUM_CMP+2:0]      wp_status,
  input logic                    bp_req,
  input logic [NUM_CMP+2:0]      bp_mask,
  input logic [NUM_CMP-1:0]      cmp_hit,
  input cmp_ctrl_t [NUM_CMP-1:0] ctrls,
  input logic [2*NUM_CMP+5:0]    link_cfg,
  input logic [NUM_CMP+2:0]      match
);

  localparam int NUM_WP = NUM_CMP + 3;

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (wp_status == '0 && !bp_req));

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_arm
    assert_hit_needs_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_hit[g] |-> (ctrls[g].armed && ctrls[g].src != SRC_NONE && ctrls[g].src != SRC_NONE_ALT));
  end

  for (genvar w = 0; w < NUM_WP; w++) begin : g_link
    assert_link_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (link_cfg[2*w +: 2] == 2'd3) |-> !match[w]);
  end

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !any_vld |=> $stable(wp_status));

  assert_bp_after_eval_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bp_req |-> $past(any_vld));

  assert_bp_on_masked_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bp_req |-> |(wp_status & ~$past(wp_status) & $past(bp_mask)));

endmodule

bind watch_chain_unit watch_chain_unit_sva #(.NUM_CMP(NUM_CMP)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .any_vld   (any_vld),
  .wp_status (wp_status),
  .bp_req    (bp_req),
  .bp_mask   (bp_mask),
  .cmp_hit   (cmp_hit),
  .ctrls     (ctrls),
  .link_cfg  (link_cfg),
  .match     (match)
);

// File: tb/watch_chain_unit_test.sv
`timescale 1ns/1ps
module watch_chain_unit_test;

  localparam int DW  = 4;
  localparam int CW  = 4;
  localparam int NC  = 8;
  localparam int CFW = 32;
  localparam int NWP = NC + 3;
  localparam int AW  = $clog2(2 * NC + 6);

  localparam int A_LINK = 16, A_SEL = 17, A_EN = 18, A_BP = 19, A_C0 = 20, A_C1 = 21;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           fetch_vld = 1'b0, ld_vld = 1'b0, st_vld = 1'b0, ext_wp = 1'b0;
  logic [DW-1:0]  fetch_addr = '0, ld_addr = '0, ld_data = '0, st_addr = '0, st_data = '0;
  logic           cfg_we = 1'b0;
  logic [AW-1:0]  cfg_addr = '0;
  logic [CFW-1:0] cfg_wdata = '0;
  logic [NWP-1:0] wp_status;
  logic           bp_req;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  watch_chain_unit #(.DATA_W(DW), .CNT_W(CW), .NUM_CMP(NC), .CFG_W(CFW)) uut (
    .clk(clk), .rst_n(rst_n),
    .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
    .ld_vld(ld_vld), .ld_addr(ld_addr), .ld_data(ld_data),
    .st_vld(st_vld), .st_addr(st_addr), .st_data(st_data),
    .ext_wp(ext_wp), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .wp_status(wp_status), .bp_req(bp_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one evaluation cycle; returns at the negedge after the capturing edge
  task automatic acc(input bit fv, input int fa, input bit lv, input int la, input int ldd,
                     input bit sv, input int sa, input int sdd, input bit ex);
    @(negedge clk);
    fetch_vld = fv; fetch_addr = DW'(fa);
    ld_vld = lv; ld_addr = DW'(la); ld_data = DW'(ldd);
    st_vld = sv; st_addr = DW'(sa); st_data = DW'(sdd);
    ext_wp = ex;
    @(negedge clk);
    fetch_vld = 1'b0; ld_vld = 1'b0; st_vld = 1'b0;
  endtask

  task automatic fetch(input int a);
    acc(1, a, 0, 0, 0, 0, 0, 0, 0);
  endtask

  function automatic logic [31:0] ctl(input int src, input int sgn, input int cond, input int arm);
    return 32'((src << 5) | (sgn << 4) | (cond << 1) | arm);
  endfunction

  function automatic bit ref_cond(input int cond, input int sgn, input int a, input int b);
    int sa, sb;
    sa = a; sb = b;
    if (sgn != 0) begin
      if (a >= 8) sa = a - 16;
      if (b >= 8) sb = b - 16;
    end
    case (cond)
      0: return (a & b) != 0;
      1: return sa == sb;
      2: return sa != sb;
      3: return sa < sb;
      4: return sa <= sb;
      5: return sa > sb;
      6: return sa >= sb;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 status after reset", 32'(wp_status), 32'h0);
    check("R1 bp after reset", 32'(bp_req), 32'h0);

    // R1/R7: reset counters equal (0==0), everything else unarmed
    fetch(3);
    check("R1 R7 reset counters equal", 32'(wp_status), 32'h300);

    wr(A_C0, 32'h10);
    wr(A_C1, 32'h10);

    // R4/R5 exhaustive comparator sweep on comparator 0, fetch address
    for (int sg = 0; sg < 2; sg++)
      for (int cc = 0; cc < 8; cc++) begin
        wr(8, ctl(1, sg, cc, 1));
        for (int v = 0; v < 16; v++) begin
          wr(0, 32'(v));
          for (int op = 0; op < 16; op++) begin
            fetch(op);
            check($sformatf("R4 R5 cond=%0d sgn=%0d val=%0d op=%0d", cc, sg, v, op),
                  32'(wp_status[0]), 32'(ref_cond(cc, sg, op, v)));
          end
        end
      end

    // R2/R3 operand select matrix, equal-to-5
    wr(0, 32'd5);
    for (int src = 0; src < 8; src++) begin
      wr(8, ctl(src, 0, 1, 1));
      for (int f = 0; f < 5; f++) begin
        bit exp_hit;
        exp_hit = (src == f + 1) || (src == 6 && (f == 1 || f == 2));
        acc(f == 0, (f == 0) ? 5 : 9,
            (f == 1 || f == 3), (f == 1) ? 5 : 9, (f == 3) ? 5 : 9,
            (f == 2 || f == 4), (f == 2) ? 5 : 9, (f == 4) ? 5 : 9, 0);
        check($sformatf("R2 R3 src=%0d field=%0d", src, f), 32'(wp_status[0]), 32'(exp_hit));
      end
    end
    wr(8, ctl(1, 0, 1, 0));
    fetch(5);
    check("R2 unarmed comparator", 32'(wp_status[0]), 32'h0);
    wr(8, ctl(1, 0, 1, 1));
    acc(0, 5, 1, 9, 9, 0, 0, 0, 0);
    check("R3 fetch operand without fetch strobe", 32'(wp_status[0]), 32'h0);
    wr(8, ctl(6, 0, 1, 1));
    acc(0, 0, 1, 9, 9, 1, 5, 9, 0);
    check("R3 load address preferred", 32'(wp_status[0]), 32'h0);
    acc(0, 0, 0, 5, 9, 1, 5, 9, 0);
    check("R3 store address when no load", 32'(wp_status[0]), 32'h1);

    // R6 chain modes on watchpoint 1
    wr(0, 32'd1); wr(8, ctl(1, 0, 0, 1));
    wr(1, 32'd2); wr(9, ctl(1, 0, 0, 1));
    for (int md = 0; md < 4; md++) begin
      wr(A_LINK, 32'(md << 2));
      for (int a = 0; a < 4; a++) begin
        bit e;
        case (md)
          0: e = a[1];
          1: e = a[1] & a[0];
          2: e = a[1] | a[0];
          default: e = 1'b0;
        endcase
        fetch(a);
        check($sformatf("R6 link mode=%0d addr=%0d", md, a), 32'(wp_status[1]), 32'(e));
      end
    end
    for (int md = 1; md < 3; md++) begin
      wr(A_LINK, 32'(md));
      fetch(1);
      check($sformatf("R6 wp0 mode=%0d self hit", md), 32'(wp_status[0]), 32'h1);
      fetch(0);
      check($sformatf("R6 wp0 mode=%0d self miss", md), 32'(wp_status[0]), 32'h0);
    end

    // R6/R7/R8 OR chain from watchpoint 0 to the top
    wr(9, 32'h0);
    begin
      logic [31:0] lk;
      lk = '0;
      for (int i = 1; i < NWP; i++) lk = lk | (32'd2 << (2 * i));
      wr(A_LINK, lk);
    end
    fetch(1);
    check("R6 R8 OR chain propagates", 32'(wp_status), 32'h7FF);
    fetch(0);
    check("R6 R8 OR chain clear", 32'(wp_status), 32'h0);

    // R7 counter own terms
    wr(A_LINK, 32'h0);
    wr(A_C0, 32'h33);
    fetch(0);
    check("R7 counter0 equal", 32'(wp_status[9:8]), 32'h1);
    wr(A_C1, 32'h22);
    fetch(0);
    check("R7 counter1 equal", 32'(wp_status[9:8]), 32'h3);
    wr(A_C0, 32'h10);
    wr(A_LINK, 32'(1 << 18));
    fetch(0);
    check("R7 wp9 AND wp8 low", 32'(wp_status[9]), 32'h0);
    wr(A_C0, 32'h33);
    fetch(0);
    check("R7 wp9 AND wp8 high", 32'(wp_status[9]), 32'h1);

    // R8 external term
    wr(A_C0, 32'h10); wr(A_C1, 32'h10);
    wr(A_LINK, 32'h0);
    acc(1, 0, 0, 0, 0, 0, 0, 0, 1);
    check("R8 external own term", 32'(wp_status[10]), 32'h1);
    acc(1, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R8 external low", 32'(wp_status[10]), 32'h0);
    wr(A_LINK, 32'(2 << 20));
    wr(A_C1, 32'h22);
    fetch(0);
    check("R8 wp10 OR wp9", 32'(wp_status[10]), 32'h1);

    // R9 hold while idle
    wr(A_C1, 32'h10);
    wr(A_LINK, 32'h0);
    fetch(1);
    check("R9 eval sets wp0", 32'(wp_status[0]), 32'h1);
    @(negedge clk);
    fetch_addr = '0; ext_wp = 1'b1;
    @(negedge clk);
    @(negedge clk);
    ext_wp = 1'b0;
    check("R9 idle cycles hold status", 32'(wp_status), 32'h1);

    // R10 counting on counter 1
    wr(A_C1, 32'h30); wr(A_EN, 32'h2); wr(A_SEL, 32'h1);
    fetch(0);
    check("R10 counter start", 32'(wp_status[9]), 32'h0);
    for (int k = 1; k <= 3; k++) begin
      fetch(1);
      fetch(0);
      check($sformatf("R10 after %0d rising matches", k), 32'(wp_status[9]), 32'(k == 3));
    end
    wr(A_C1, 32'h20);
    fetch(1);
    fetch(1);
    fetch(1);
    check("R10 held match does not count", 32'(wp_status[9]), 32'h0);
    fetch(0);
    fetch(1);
    fetch(0);
    check("R10 second rise counts", 32'(wp_status[9]), 32'h1);
    wr(A_EN, 32'h0); wr(A_C1, 32'h10);
    fetch(1);
    fetch(0);
    check("R10 disabled counter holds", 32'(wp_status[9]), 32'h0);
    wr(A_EN, 32'h1); wr(A_SEL, 32'h0); wr(A_C0, 32'h10);
    fetch(1);
    fetch(0);
    check("R10 select routes to counter0", 32'(wp_status[9:8]), 32'h1);
    wr(A_EN, 32'h2); wr(A_SEL, 32'h3); wr(A_C1, 32'h20); wr(A_C0, 32'h10);
    wr(1, 32'd1); wr(9, ctl(1, 0, 1, 1));
    fetch(1);
    fetch(0);
    check("R10 two new matches add two", 32'(wp_status[9]), 32'h1);
    wr(9, 32'h0); wr(A_SEL, 32'h1);
    wr(A_C1, 32'h0F);
    fetch(1);
    fetch(0);
    check("R10 counter wraps to zero", 32'(wp_status[9]), 32'h1);

    // R12 write wins over step in the same cycle
    wr(A_C1, 32'h10);
    fetch(0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(A_C1); cfg_wdata = 32'h55;
    fetch_vld = 1'b1; fetch_addr = DW'(1);
    @(negedge clk);
    cfg_we = 1'b0; fetch_vld = 1'b0;
    fetch(0);
    check("R12 counter write beats step", 32'(wp_status[9]), 32'h1);

    // R12 unmapped write leaves configuration intact
    wr(30, 32'hFFFF_FFFF);
    fetch(1);
    check("R12 unmapped write ignored", 32'(wp_status), 32'h201);

    // R11 breakpoint request
    wr(A_EN, 32'h0); wr(A_C1, 32'h10);
    wr(A_BP, 32'h1);
    fetch(0);
    check("R11 no match no bp", 32'(bp_req), 32'h0);
    fetch(1);
    check("R11 rising match raises bp", 32'(bp_req), 32'h1);
    @(negedge clk);
    check("R11 bp lasts one cycle", 32'(bp_req), 32'h0);
    fetch(1);
    check("R11 held match no bp", 32'(bp_req), 32'h0);
    wr(A_BP, 32'h2);
    fetch(0);
    fetch(1);
    check("R11 masked-off watchpoint no bp", 32'(bp_req), 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule